// File: doc/BRIEF.md
# Host-Target Mailbox Console

This block is a memory-mapped mailbox between a target processor and a host-side console. It holds two 64-bit registers: a command mailbox written by the processor and a response mailbox read back by it. The processor reaches each register through a 32-bit bus as a low word and a high word. A command is assembled from two writes. The low-word write is taken only while the command mailbox is empty. The high-word write completes the command and starts a small engine, which decodes the 64-bit word into a device byte (bits 63:56), an operation byte (bits 55:48) and a 48-bit payload (bits 47:0).

The engine acts on the decoded command. It can report a test exit code, send one byte out of a valid/ready transmit port, or remember a pending console read. After a command it posts a response, tagged with the command's top 16 bits, into the response mailbox and then clears the command mailbox to show that it has taken the command. A byte arriving on the receive port is written into the response mailbox at once. It is tagged with the top 16 bits of the last pending-read command.

The engine has three states. IDLE waits for an accepted high-word write (IDLE->DECODE). DECODE lasts one cycle. From DECODE a transmit command goes to SEND (DECODE->SEND), and every other command completes and returns (DECODE->IDLE). SEND presents the byte until the consumer accepts it, then posts the response (SEND->IDLE).

Top module: `hmbx_console`

## Requirements
- R1: After reset both mailboxes read as zero, the read data is zero, and exit_valid, tx_valid and bus_err are low.
- R2: A read sampled at byte offset TOHOST_OFS, TOHOST_OFS+4, FROMHOST_OFS or FROMHOST_OFS+4 returns bits 31:0 or 63:32 of the command or response mailbox. The value appears on bus_rdata in the cycle after bus_rd and holds until the next read. Any other offset reads zero.
- R3: A write to the command low word while the engine is idle loads bits 31:0 with the upper half zero and arms the high-word write, but only if the command mailbox is zero. If the mailbox is nonzero, the write has no effect on the mailbox and disarms the high-word write.
- R4: A write to the command high word ORs the data into bits 63:32 only when the high-word write is armed and the engine is idle, and it then starts the engine. When not armed, it has no effect.
- R5: Device 0x00 operation 0x00 with payload bit 0 set raises exit_valid for exactly one cycle, the cycle after the high-word write. exit_code carries the payload shifted right by one, zero-extended to 63 bits. The response mailbox becomes {command bits 63:48, 48'h0} and the command mailbox is cleared.
- R6: Device 0x01 operation 0x01 holds tx_valid high with tx_data = payload bits 7:0 until tx_ready. After acceptance the response mailbox becomes {command bits 63:48, 48'h100 | byte} and the command mailbox is cleared.
- R7: Device 0x01 operation 0x00 stores command bits 63:48 as the pending-read tag and clears the command mailbox. The response mailbox is left unchanged.
- R8: Every other command, including device 0x00 operation 0x00 with payload bit 0 clear, posts {command bits 63:48, 48'h0} and clears the command mailbox.
- R9: A receive byte (rx_valid) is always taken. It sets the response mailbox to {pending tag, 48'h100 | byte}, overwriting any earlier value.
- R10: A write to the response low word sets that mailbox to the data zero-extended. A write to the response high word ORs the data into bits 63:32.
- R11: A write at any offset other than the four mailbox words changes no state and raises bus_err for one cycle, the cycle after the write.
- R12: In one cycle a command completion takes precedence over a receive byte, and a receive byte takes precedence over a processor write to the response mailbox.
- R13: While the engine is busy, writes to the command mailbox have no effect, so the byte and mailbox stay stable during a stalled transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle pulse after a write to an unmapped offset |
| exit_valid | output | 1 | Exit report pulse |
| exit_code | output | 63 | Exit code, valid with exit_valid |
| tx_valid | output | 1 | Console byte available |
| tx_data | output | 8 | Console byte |
| tx_ready | input | 1 | Console consumer accepts the byte |
| rx_valid | input | 1 | Received console byte strobe |
| rx_data | input | 8 | Received console byte |

## Verification
Command-mailbox writes during a busy engine are the hardest case to reach. In DECODE the mailbox is cleared on the very edge that would show a stray write. The bench therefore holds tx_ready low to keep the engine in SEND. It then issues a high-word write while the arm flag is still set and reads the mailbox back before releasing the consumer. The same-cycle priority cases are reached the same way: a receive strobe is placed in the DECODE cycle, and a receive byte is sent together with a response-mailbox write.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
    localparam int WORD_W    = 32;
    localparam int MBOX_W    = 2 * WORD_W;
    localparam int TAG_W     = 16;
    localparam int PAYLOAD_W = MBOX_W - TAG_W;
    localparam int BYTE_W    = 8;
    localparam int EXIT_W    = 63;

    localparam logic [7:0] DEV_CTRL = 8'h00;
    localparam logic [7:0] DEV_CONS = 8'h01;
    localparam logic [7:0] OP_ZERO  = 8'h00;
    localparam logic [7:0] OP_ONE   = 8'h01;

    localparam logic [PAYLOAD_W-1:0] ECHO_FLAG = PAYLOAD_W'(9'h100);

    typedef enum logic [1:0] {
        K_NOP,
        K_EXIT,
        K_PUTC,
        K_GETC
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_SEND
    } eng_state_e;
endpackage

// File: rtl/hmbx_decode.sv
module hmbx_decode
    import hmbx_pkg::*;
(
    input  logic [MBOX_W-1:0]    cmd_word,
    output cmd_kind_e            kind,
    output logic [PAYLOAD_W-1:0] payload
);
    logic [7:0] dev;
    logic [7:0] op;

    assign dev     = cmd_word[MBOX_W-1 -: 8];
    assign op      = cmd_word[MBOX_W-9 -: 8];
    assign payload = cmd_word[PAYLOAD_W-1:0];

    always_comb begin
        kind = K_NOP;
        if (dev == DEV_CTRL && op == OP_ZERO && payload[0]) begin
            kind = K_EXIT;
        end else if (dev == DEV_CONS && op == OP_ONE) begin
            kind = K_PUTC;
        end else if (dev == DEV_CONS && op == OP_ZERO) begin
            kind = K_GETC;
        end
    end
endmodule

// File: rtl/hmbx_fsm.sv
module hmbx_fsm
    import hmbx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  cmd_kind_e            kind,
    input  logic [BYTE_W-1:0]    tx_byte,
    input  logic                 tx_ready,
    output eng_state_e           state,
    output logic                 busy,
    output logic                 exit_fire,
    output logic                 tx_valid,
    output logic                 post_en,
    output logic [PAYLOAD_W-1:0] post_resp,
    output logic                 save_pend
);
    eng_state_e state_q;
    eng_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_DECODE;
            ST_DECODE: state_d = (kind == K_PUTC) ? ST_SEND : ST_IDLE;
            ST_SEND:   if (tx_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy      = 1'b1;
        exit_fire = 1'b0;
        tx_valid  = 1'b0;
        post_en   = 1'b0;
        post_resp = '0;
        save_pend = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_DECODE: begin
                exit_fire = (kind == K_EXIT);
                save_pend = (kind == K_GETC);
                post_en   = (kind == K_EXIT) || (kind == K_NOP);
            end
            ST_SEND: begin
                tx_valid  = 1'b1;
                post_en   = tx_ready;
                post_resp = ECHO_FLAG | PAYLOAD_W'(tx_byte);
            end
            default: busy = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/hmbx_regs.sv
module hmbx_regs
    import hmbx_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int TOHOST_OFS   = 0,
    parameter int FROMHOST_OFS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic                 busy,
    input  logic                 post_en,
    input  logic [PAYLOAD_W-1:0] post_resp,
    input  logic                 save_pend,
    input  logic                 rx_valid,
    input  logic [BYTE_W-1:0]    rx_data,
    output logic [MBOX_W-1:0]    tohost,
    output logic                 start,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic                 bus_err
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam logic [ADDR_W-1:0] A_TH_LO = ADDR_W'(TOHOST_OFS);
    localparam logic [ADDR_W-1:0] A_TH_HI = ADDR_W'(TOHOST_OFS + WORD_BYTES);
    localparam logic [ADDR_W-1:0] A_FH_LO = ADDR_W'(FROMHOST_OFS);
    localparam logic [ADDR_W-1:0] A_FH_HI = ADDR_W'(FROMHOST_OFS + WORD_BYTES);

    logic [MBOX_W-1:0] th_q;
    logic [MBOX_W-1:0] fh_q;
    logic [TAG_W-1:0]  pend_tag_q;
    logic              armed_q;
    logic [WORD_W-1:0] rdata_q;
    logic              err_q;
    logic [WORD_W-1:0] rd_mux;

    logic hit_th_lo, hit_th_hi, hit_fh_lo, hit_fh_hi, hit_any;

    assign hit_th_lo = (bus_addr == A_TH_LO);
    assign hit_th_hi = (bus_addr == A_TH_HI);
    assign hit_fh_lo = (bus_addr == A_FH_LO);
    assign hit_fh_hi = (bus_addr == A_FH_HI);
    assign hit_any   = hit_th_lo | hit_th_hi | hit_fh_lo | hit_fh_hi;

    assign start = bus_wr && hit_th_hi && armed_q && !busy;

    // Command mailbox and arm flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            th_q    <= '0;
            armed_q <= 1'b0;
        end else if (post_en || save_pend) begin
            th_q <= '0;
        end else if (bus_wr && hit_th_lo && !busy) begin
            if (th_q == '0) begin
                th_q    <= {{WORD_W{1'b0}}, bus_wdata};
                armed_q <= 1'b1;
            end else begin
                armed_q <= 1'b0;
            end
        end else if (start) begin
            th_q[MBOX_W-1:WORD_W] <= th_q[MBOX_W-1:WORD_W] | bus_wdata;
        end
    end

    // Pending-read tag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tag_q <= '0;
        end else if (save_pend) begin
            pend_tag_q <= th_q[MBOX_W-1 -: TAG_W];
        end
    end

    // Response mailbox: completion over receive over processor write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fh_q <= '0;
        end else if (post_en) begin
            fh_q <= {th_q[MBOX_W-1 -: TAG_W], post_resp};
        end else if (rx_valid) begin
            fh_q <= {pend_tag_q, ECHO_FLAG | PAYLOAD_W'(rx_data)};
        end else if (bus_wr && hit_fh_lo) begin
            fh_q <= {{WORD_W{1'b0}}, bus_wdata};
        end else if (bus_wr && hit_fh_hi) begin
            fh_q[MBOX_W-1:WORD_W] <= fh_q[MBOX_W-1:WORD_W] | bus_wdata;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_th_lo)      rd_mux = th_q[WORD_W-1:0];
        else if (hit_th_hi) rd_mux = th_q[MBOX_W-1:WORD_W];
        else if (hit_fh_lo) rd_mux = fh_q[WORD_W-1:0];
        else if (hit_fh_hi) rd_mux = fh_q[MBOX_W-1:WORD_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (bus_rd) rdata_q <= rd_mux;
            err_q <= bus_wr && !hit_any;
        end
    end

    assign tohost    = th_q;
    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
endmodule

// File: rtl/hmbx_console.sv
module hmbx_console
    import hmbx_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int TOHOST_OFS   = 0,
    parameter int FROMHOST_OFS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              exit_valid,
    output logic [62:0]       exit_code,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data
);
    logic [MBOX_W-1:0]    th_word;
    logic [PAYLOAD_W-1:0] payload;
    logic [PAYLOAD_W-1:0] post_resp;
    cmd_kind_e            kind;
    eng_state_e           eng_state;
    logic                 start, busy, post_en, save_pend, exit_fire;

    hmbx_decode u_decode (
        .cmd_word (th_word),
        .kind     (kind),
        .payload  (payload)
    );

    hmbx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind      (kind),
        .tx_byte   (payload[BYTE_W-1:0]),
        .tx_ready  (tx_ready),
        .state     (eng_state),
        .busy      (busy),
        .exit_fire (exit_fire),
        .tx_valid  (tx_valid),
        .post_en   (post_en),
        .post_resp (post_resp),
        .save_pend (save_pend)
    );

    hmbx_regs #(
        .ADDR_W       (ADDR_W),
        .TOHOST_OFS   (TOHOST_OFS),
        .FROMHOST_OFS (FROMHOST_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .post_en   (post_en),
        .post_resp (post_resp),
        .save_pend (save_pend),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .tohost    (th_word),
        .start     (start),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    assign exit_valid = exit_fire && (eng_state == ST_DECODE);
    assign exit_code  = EXIT_W'(payload >> 1);
    assign tx_data    = payload[BYTE_W-1:0];
endmodule

// File: rtl/hmbx_console_chk.sv
module hmbx_console_chk #(
    parameter int ADDR_W       = 8,
    parameter int TOHOST_OFS   = 0,
    parameter int FROMHOST_OFS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_err,
    input logic              exit_valid,
    input logic [62:0]       exit_code,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic [63:0]       th_word,
    input logic              busy
);
    localparam logic [ADDR_W-1:0] C_TH_LO = ADDR_W'(TOHOST_OFS);
    localparam logic [ADDR_W-1:0] C_TH_HI = ADDR_W'(TOHOST_OFS + 4);
    localparam logic [ADDR_W-1:0] C_FH_LO = ADDR_W'(FROMHOST_OFS);
    localparam logic [ADDR_W-1:0] C_FH_HI = ADDR_W'(FROMHOST_OFS + 4);

    logic mapped;
    assign mapped = (bus_addr == C_TH_LO) || (bus_addr == C_TH_HI) ||
                    (bus_addr == C_FH_LO) || (bus_addr == C_FH_HI);

    a_r5_exit_single: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |=> !exit_valid);

    a_r5_exit_width: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> (exit_code[62:47] == '0));

    a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    a_r6_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (th_word == '0));

    a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> bus_err);

    a_r3_low_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == C_TH_LO && th_word != '0 && !busy) |=> $stable(th_word));

    a_r13_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> $stable(th_word));
endmodule

bind hmbx_console hmbx_console_chk #(
    .ADDR_W       (ADDR_W),
    .TOHOST_OFS   (TOHOST_OFS),
    .FROMHOST_OFS (FROMHOST_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_err    (bus_err),
    .exit_valid (exit_valid),
    .exit_code  (exit_code),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .th_word    (th_word),
    .busy       (busy)
);

// File: tb/hmbx_console_test.sv
module hmbx_console_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err, exit_valid, tx_valid;
    logic [62:0] exit_code;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [62:0] exit_q[$];
    logic [7:0]  tx_q[$];

    always #4 clk = ~clk;

    hmbx_console uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .exit_valid(exit_valid), .exit_code(exit_code),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, 64'(bus_rdata), 64'(exp));
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pops expected exit codes and console bytes
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (exit_valid) begin
                    if (exit_q.size() == 0) check("R5 unexpected exit", 64'(exit_code), 64'hFFFF);
                    else check("R5 exit code", 64'(exit_code), 64'(exit_q.pop_front()));
                end
                if (tx_valid && tx_ready) begin
                    if (tx_q.size() == 0) check("R6 unexpected byte", 64'(tx_data), 64'hFFFF);
                    else check("R6 console byte", 64'(tx_data), 64'(tx_q.pop_front()));
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 exit_valid", 64'(exit_valid), 0);
        check("R1 tx_valid", 64'(tx_valid), 0);
        check("R1 bus_err", 64'(bus_err), 0);
        check("R1 rdata", 64'(bus_rdata), 0);
        rd_check("R1 tohost lo", 8'h00, 0);
        rd_check("R1 fromhost hi", 8'h0C, 0);

        // R3/R2 low write loads, R8 unknown command
        wr(8'h00, 32'hAA);
        rd_check("R3 tohost lo loaded", 8'h00, 32'hAA);
        rd_check("R2 tohost hi", 8'h04, 0);
        wr(8'h04, 32'h0302_0000);
        settle();
        rd_check("R8 fromhost lo", 8'h08, 0);
        rd_check("R8 fromhost hi tag", 8'h0C, 32'h0302_0000);
        rd_check("R8 tohost cleared", 8'h04, 0);

        // R3 blocked low write disarms, R4 unarmed high write ignored
        wr(8'h00, 32'h11);
        wr(8'h00, 32'h22);
        rd_check("R3 nonzero blocks", 8'h00, 32'h11);
        wr(8'h04, 32'h0101_0000);
        settle();
        rd_check("R4 unarmed high ignored", 8'h04, 0);
        check("R4 no tx", 64'(tx_valid), 0);
        do_reset();

        // R6 transmit with ready
        tx_ready = 1'b1;
        tx_q.push_back(8'h41);
        wr(8'h00, 32'h41);
        wr(8'h04, 32'h0101_0000);
        settle();
        rd_check("R6 fromhost lo", 8'h08, 32'h141);
        rd_check("R6 fromhost hi", 8'h0C, 32'h0101_0000);
        rd_check("R6 tohost cleared", 8'h00, 0);

        // R6/R13 stalled transmit; high write while busy ignored
        tx_ready = 1'b0;
        tx_q.push_back(8'h5A);
        wr(8'h00, 32'h5A);
        wr(8'h04, 32'h0101_0000);
        repeat (3) @(negedge clk);
        check("R6 tx_valid held", 64'(tx_valid), 1);
        check("R6 tx_data held", 64'(tx_data), 64'h5A);
        wr(8'h04, 32'h00FF_0000);
        rd_check("R13 tohost hi unchanged", 8'h04, 32'h0101_0000);
        rd_check("R13 tohost lo unchanged", 8'h00, 32'h5A);
        tx_ready = 1'b1;
        settle();
        rd_check("R6 stalled fromhost lo", 8'h08, 32'h15A);

        // R5 exit
        exit_q.push_back(63'h9_0000_0003);
        wr(8'h00, 32'h7);
        wr(8'h04, 32'h0000_0012);
        settle();
        rd_check("R5 fromhost lo", 8'h08, 0);
        rd_check("R5 fromhost hi", 8'h0C, 0);
        rd_check("R5 tohost cleared", 8'h04, 0);

        // R10 processor writes to response mailbox
        wr(8'h08, 32'hDEAD);
        rd_check("R10 fromhost lo", 8'h08, 32'hDEAD);
        wr(8'h0C, 32'hBEEF);
        rd_check("R10 fromhost hi or", 8'h0C, 32'hBEEF);
        wr(8'h08, 32'h1);
        rd_check("R10 low zero-extends", 8'h0C, 0);

        // R8 exit op with bit0 clear: no exit, zero response
        wr(8'h00, 32'h6);
        wr(8'h04, 32'h0);
        settle();
        rd_check("R8 bit0 clear response", 8'h08, 0);

        // R7 pending read leaves response untouched
        wr(8'h08, 32'h77);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'h0100_0000);
        settle();
        rd_check("R7 tohost cleared", 8'h04, 0);
        rd_check("R7 fromhost unchanged", 8'h08, 32'h77);

        // R9 receive bytes overwrite
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h51;
        @(negedge clk); rx_valid = 1'b0;
        rd_check("R9 rx lo", 8'h08, 32'h151);
        rd_check("R9 rx tag", 8'h0C, 32'h0100_0000);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h52;
        @(negedge clk); rx_valid = 1'b0;
        rd_check("R9 rx overwrite", 8'h08, 32'h152);

        // R11 unmapped write
        wr(8'h20, 32'hFFFF_FFFF);
        check("R11 bus_err pulse", 64'(bus_err), 1);
        @(negedge clk);
        check("R11 bus_err drops", 64'(bus_err), 0);
        rd_check("R11 state unchanged", 8'h08, 32'h152);
        rd_check("R2 unmapped read", 8'h20, 0);

        // R12 completion beats receive
        wr(8'h00, 32'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0505_0000;
        @(negedge clk);
        bus_wr = 1'b0; rx_valid = 1'b1; rx_data = 8'h44;
        @(negedge clk);
        rx_valid = 1'b0;
        settle();
        rd_check("R12 post wins lo", 8'h08, 0);
        rd_check("R12 post wins hi", 8'h0C, 32'h0505_0000);

        // R12 receive beats processor write
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'hAAAA;
        rx_valid = 1'b1; rx_data = 8'h63;
        @(negedge clk);
        bus_wr = 1'b0; rx_valid = 1'b0;
        rd_check("R12 rx wins lo", 8'h08, 32'h163);
        rd_check("R12 rx wins hi", 8'h0C, 32'h0100_0000);

        settle();
        check("R5 exit queue drained", 64'(exit_q.size()), 0);
        check("R6 tx queue drained", 64'(tx_q.size()), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule